// File: doc/BRIEF.md
# Dual-CPU Paged Memory Mapper

This block sits between two 8-bit processors and a shared paged RAM of 256 KB. Each processor's 16-bit address is split into a 2 KB page number and an in-page offset. The page number, combined with a map selector taken from that processor's own control register, indexes a shared table of 1024 page entries. Each entry says whether the page is present and which of 128 physical pages backs it. The block does not hold the RAM, video memory or peripherals. For every access it names a target and the address within that target, and it returns read data one cycle later.

Each processor's control register picks one of 32 maps. It also decides whether the video window at 0x8000–0xBFFF and the card and peripheral windows at the top of the address space cover the paged RAM. A third control bit puts the processor into a parity-diagnostic mode, in which reads of the general RAM ranges raise an interrupt request. The page table is filled through the peripheral window in two steps: a write that loads a staging latch, then a write that stores the entry.

Top module: `dual_cpu_page_mapper`

## Requirements
- R1: While reset is held, and right after it, both control registers read 0x00, `perr_irq` is 0, both `cX_rdata` are 0x00 and both `cX_tgt` are 0.
- R2: Target codes are 0 none, 1 RAM, 2 video, 3 card, 4 peripheral. Any access that no window claims reads entry {ctrl[4:0], addr[15:11]}. If bit 7 of that entry is set, the target is 1 and `taddr` is {entry[6:0], addr[10:0]}.
- R3: If that entry's bit 7 is clear, the target is 0 and `taddr` is 0. `wr` stays low, and the read data in the next cycle is 0x00.
- R4: When ctrl bit 5 is 0, addresses 0x8000–0xBFFF give target 2 with `taddr` = addr[13:0]. When bit 5 is 1, these addresses are paged.
- R5: When ctrl bit 7 is 0, 0xE000–0xE03F gives target 3 with `taddr` = addr[5:0], and 0xF000–0xFFFF gives target 4 with `taddr` = addr[11:0]. When bit 7 is 1, both ranges are paged.
- R6: A read with ctrl bit 6 set, to 0x0000–0x7FFF or 0xC000–0xDFFF, sets `perr_irq` at the next edge. A read of 0xFC40–0xFC4F with target 4 returns 0xFF and clears `perr_irq`. If both happen in the same cycle, the flag stays set.
- R7: A write with target 4 to 0xF000–0xF7FF updates the page table. At an even address it loads the latch. At an odd address it stores entry addr[10:1] with bits 6:0 taken from data[6:0], and bit 7 set only if latch bit 7 is 1 and latch bits 2:0 are 0.
- R8: When both processors write the page table (latch or entry) in the same cycle, only processor 0's write takes effect.
- R9: For a read with target 1–4 that is not a status read, `cX_rdata` in the following cycle equals `cX_ext_rdata`. A cycle that follows no read gives 0x00.
- R10: `cX_info_we` loads `cX_info_wdata` into that processor's control register only, and the new value is used from the next cycle on.
- R11: When `cX_req` is low, `cX_tgt` is 0 and `cX_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Processor 0 access valid |
| c0_we | input | 1 | Processor 0 write |
| c0_addr | input | 16 | Processor 0 address |
| c0_wdata | input | 8 | Processor 0 write data |
| c0_ext_rdata | input | 8 | Data returned by processor 0's selected target |
| c0_info_we | input | 1 | Load processor 0 control register |
| c0_info_wdata | input | 8 | New processor 0 control value |
| c0_tgt | output | 3 | Processor 0 decoded target |
| c0_taddr | output | 18 | Processor 0 address within the target |
| c0_wr | output | 1 | Processor 0 write strobe to the target |
| c0_rdata | output | 8 | Processor 0 read data, one cycle after the read |
| c0_info | output | 8 | Processor 0 control register |
| c1_req | input | 1 | Processor 1 access valid |
| c1_we | input | 1 | Processor 1 write |
| c1_addr | input | 16 | Processor 1 address |
| c1_wdata | input | 8 | Processor 1 write data |
| c1_ext_rdata | input | 8 | Data returned by processor 1's selected target |
| c1_info_we | input | 1 | Load processor 1 control register |
| c1_info_wdata | input | 8 | New processor 1 control value |
| c1_tgt | output | 3 | Processor 1 decoded target |
| c1_taddr | output | 18 | Processor 1 address within the target |
| c1_wr | output | 1 | Processor 1 write strobe to the target |
| c1_rdata | output | 8 | Processor 1 read data, one cycle after the read |
| c1_info | output | 8 | Processor 1 control register |
| perr_irq | output | 1 | Parity-diagnostic interrupt request |

## Verification
The bench aims at the window edges (0x7FFF/0x8000, 0xBFFF/0xC000, 0xE03F/0xE040, 0xEFFF/0xF000). A decoder with an off-by-one there would send a paged access to video or to a card, or the reverse. It stores entries through a latch whose card bits do not match, and checks that those pages stay absent. A design that ignored the card qualifier would map them. It makes both processors write the table in the same cycle, which catches a design where processor 1 wins or where both writes merge. It also issues a parity read and a status read in the same cycle, which catches a design that lets the clear win and drops the interrupt.

// File: rtl/dual_cpu_page_mapper.sv
`timescale 1ns/1ps
module dual_cpu_page_mapper #(
  parameter int MAP_SEL_W = 5,
  parameter int PAGE_W    = 5,
  parameter int OFF_W     = 11,
  parameter int PPN_W     = 7,
  parameter int DW        = 8,
  parameter int CARD_ID   = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     c0_req,
  input  logic                     c0_we,
  input  logic [PAGE_W+OFF_W-1:0]  c0_addr,
  input  logic [DW-1:0]            c0_wdata,
  input  logic [DW-1:0]            c0_ext_rdata,
  input  logic                     c0_info_we,
  input  logic [7:0]               c0_info_wdata,
  output logic [2:0]               c0_tgt,
  output logic [PPN_W+OFF_W-1:0]   c0_taddr,
  output logic                     c0_wr,
  output logic [DW-1:0]            c0_rdata,
  output logic [7:0]               c0_info,
  input  logic                     c1_req,
  input  logic                     c1_we,
  input  logic [PAGE_W+OFF_W-1:0]  c1_addr,
  input  logic [DW-1:0]            c1_wdata,
  input  logic [DW-1:0]            c1_ext_rdata,
  input  logic                     c1_info_we,
  input  logic [7:0]               c1_info_wdata,
  output logic [2:0]               c1_tgt,
  output logic [PPN_W+OFF_W-1:0]   c1_taddr,
  output logic                     c1_wr,
  output logic [DW-1:0]            c1_rdata,
  output logic [7:0]               c1_info,
  output logic                     perr_irq
);
  localparam int AW      = PAGE_W + OFF_W;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int IDX_W   = MAP_SEL_W + PAGE_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int ENT_W   = PPN_W + 1;
  localparam int PER_W   = 12;
  localparam logic [2:0] T_NONE = 3'd0, T_RAM = 3'd1, T_VID = 3'd2,
                         T_CARD = 3'd3, T_PER = 3'd4;

  logic [ENT_W-1:0] map_q [ENTRIES];
  logic             lat_on_q;
  logic [2:0]       lat_card_q;
  logic             irq_q;

  logic             req_a   [2];
  logic             we_a    [2];
  logic [AW-1:0]    addr_a  [2];
  logic [DW-1:0]    wdata_a [2];
  logic [DW-1:0]    ext_a   [2];
  logic             iwe_a   [2];
  logic [7:0]       iwd_a   [2];
  logic [2:0]       tgt_a   [2];
  logic [PA_W-1:0]  ta_a    [2];
  logic             wr_a    [2];
  logic [DW-1:0]    rd_a    [2];
  logic [7:0]       info_a  [2];
  logic             mw_a    [2];
  logic             par_a   [2];
  logic             stat_a  [2];

  assign req_a[0] = c0_req;        assign req_a[1] = c1_req;
  assign we_a[0] = c0_we;          assign we_a[1] = c1_we;
  assign addr_a[0] = c0_addr;      assign addr_a[1] = c1_addr;
  assign wdata_a[0] = c0_wdata;    assign wdata_a[1] = c1_wdata;
  assign ext_a[0] = c0_ext_rdata;  assign ext_a[1] = c1_ext_rdata;
  assign iwe_a[0] = c0_info_we;    assign iwe_a[1] = c1_info_we;
  assign iwd_a[0] = c0_info_wdata; assign iwd_a[1] = c1_info_wdata;

  assign c0_tgt = tgt_a[0];   assign c1_tgt = tgt_a[1];
  assign c0_taddr = ta_a[0];  assign c1_taddr = ta_a[1];
  assign c0_wr = wr_a[0];     assign c1_wr = wr_a[1];
  assign c0_rdata = rd_a[0];  assign c1_rdata = rd_a[1];
  assign c0_info = info_a[0]; assign c1_info = info_a[1];
  assign perr_irq = irq_q;

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic [AW-1:0]    a;
    logic [7:0]       inf_q;
    logic [ENT_W-1:0] ent;
    logic [2:0]       t;
    logic [PA_W-1:0]  ta;
    logic             rd;
    logic             in_vid, in_card, in_per;
    logic [2:0]       rt_q;
    logic             rs_q;

    assign a       = addr_a[g];
    assign rd      = req_a[g] & ~we_a[g];
    assign in_vid  = ~inf_q[5] & (a[AW-1:AW-2] == 2'b10);
    assign in_card = ~inf_q[7] & (a[AW-1:AW-4] == 4'hE) & (a[AW-5:6] == '0);
    assign in_per  = ~inf_q[7] & (a[AW-1:AW-4] == 4'hF);
    assign ent     = map_q[{inf_q[MAP_SEL_W-1:0], a[AW-1:OFF_W]}];

    always_comb begin
      t  = T_NONE;
      ta = '0;
      if (req_a[g]) begin
        if (in_vid) begin
          t  = T_VID;
          ta = PA_W'(a[AW-3:0]);
        end else if (in_card) begin
          t  = T_CARD;
          ta = PA_W'(a[5:0]);
        end else if (in_per) begin
          t  = T_PER;
          ta = PA_W'(a[PER_W-1:0]);
        end else if (ent[ENT_W-1]) begin
          t  = T_RAM;
          ta = {ent[PPN_W-1:0], a[OFF_W-1:0]};
        end
      end
    end

    assign tgt_a[g]  = t;
    assign ta_a[g]   = ta;
    assign wr_a[g]   = req_a[g] & we_a[g] & (t != T_NONE);
    assign mw_a[g]   = req_a[g] & we_a[g] & (t == T_PER) & ~a[PER_W-1];
    assign stat_a[g] = rd & (t == T_PER) & (a[PER_W-1:4] == 8'hC4);
    assign par_a[g]  = rd & inf_q[6] & (~a[AW-1] | (a[AW-1:AW-3] == 3'b110));
    assign info_a[g] = inf_q;
    assign rd_a[g]   = (rt_q == T_NONE) ? '0 : rs_q ? '1 : ext_a[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inf_q <= '0;
        rt_q  <= T_NONE;
        rs_q  <= 1'b0;
      end else begin
        if (iwe_a[g]) inf_q <= iwd_a[g];
        rt_q <= rd ? t : T_NONE;
        rs_q <= stat_a[g];
      end
    end
  end

  logic             mw_any, mw_sel, mw_odd;
  logic [DW-1:0]    mw_data;
  logic [IDX_W-1:0] mw_idx;

  assign mw_any  = mw_a[0] | mw_a[1];
  assign mw_sel  = ~mw_a[0];
  assign mw_odd  = addr_a[mw_sel][0];
  assign mw_data = wdata_a[mw_sel];
  assign mw_idx  = addr_a[mw_sel][IDX_W:1];

  always_ff @(posedge clk) begin
    if (mw_any && mw_odd)
      map_q[mw_idx] <= {lat_on_q & (lat_card_q == 3'(CARD_ID)), mw_data[PPN_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_on_q   <= 1'b0;
      lat_card_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (mw_any && !mw_odd) begin
        lat_on_q   <= mw_data[DW-1];
        lat_card_q <= mw_data[2:0];
      end
      if (par_a[0] | par_a[1]) irq_q <= 1'b1;
      else if (stat_a[0] | stat_a[1]) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_cpu_page_mapper_chk.sv
`timescale 1ns/1ps
module dual_cpu_page_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        c0_req,
  input logic        c0_we,
  input logic [15:0] c0_addr,
  input logic        c0_info_we,
  input logic [2:0]  c0_tgt,
  input logic        c0_wr,
  input logic [7:0]  c0_rdata,
  input logic [7:0]  c0_info,
  input logic        c1_req,
  input logic [15:0] c1_addr,
  input logic [2:0]  c1_tgt,
  input logic        c1_wr,
  input logic [7:0]  c1_info,
  input logic        perr_irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (c0_info == 8'h00 && c1_info == 8'h00 && !perr_irq));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !c1_req |-> (c1_tgt == 3'd0 && !c1_wr));

  assert_absent_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_tgt == 3'd0) |-> !c0_wr);

  assert_absent_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && !c0_we && c0_tgt == 3'd0) |=> (c0_rdata == 8'h00));

  assert_video_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && !c0_info[5] && c0_addr[15:14] == 2'b10) |-> (c0_tgt == 3'd2));

  assert_periph_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_req && !c1_info[7] && c1_addr[15:12] == 4'hF) |-> (c1_tgt == 3'd4));

  assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req && !c0_we && c0_info[6] && !c0_addr[15]) |=> perr_irq);

  assert_info_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !c0_info_we |=> $stable(c0_info));
endmodule

bind dual_cpu_page_mapper dual_cpu_page_mapper_chk i_chk (.*);

// File: tb/test_dual_cpu_page_mapper.sv
`timescale 1ns/1ps
module test_dual_cpu_page_mapper;
  logic clk = 1'b0, rst_n = 1'b0;
  logic c0_req = 0, c0_we = 0, c0_info_we = 0, c1_req = 0, c1_we = 0, c1_info_we = 0;
  logic [15:0] c0_addr = 0, c1_addr = 0;
  logic [7:0] c0_wdata = 0, c1_wdata = 0, c0_ext_rdata = 0, c1_ext_rdata = 0;
  logic [7:0] c0_info_wdata = 0, c1_info_wdata = 0;
  logic [2:0] c0_tgt, c1_tgt;
  logic [17:0] c0_taddr, c1_taddr;
  logic c0_wr, c1_wr, perr_irq;
  logic [7:0] c0_rdata, c1_rdata, c0_info, c1_info;

  dual_cpu_page_mapper i_dual_cpu_page_mapper (.*);

  always #10 clk = ~clk;

  logic [7:0] m_map [1024];
  logic [7:0] m_latch = 8'h00;
  logic [7:0] m_info [2];
  logic m_irq = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [20:0] mdec(input logic rq, input logic [7:0] inf, input logic [15:0] a);
    logic [7:0] e;
    if (!rq) return '0;
    if (!inf[5] && a[15:14] == 2'b10) return {3'd2, 4'd0, a[13:0]};
    if (!inf[7] && a[15:6] == 10'h380) return {3'd3, 12'd0, a[5:0]};
    if (!inf[7] && a[15:12] == 4'hF) return {3'd4, 6'd0, a[11:0]};
    e = m_map[{inf[4:0], a[15:11]}];
    if (e[7]) return {3'd1, e[6:0], a[10:0]};
    return '0;
  endfunction

  function automatic string ttag(input logic [2:0] t);
    case (t)
      3'd0: return "R3";
      3'd1: return "R2";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic mapwr(input logic [15:0] a, input logic [7:0] d);
    if (!a[0]) m_latch = d;
    else m_map[a[10:1]] = {m_latch[7] && m_latch[2:0] == 3'd0, d[6:0]};
  endtask

  task automatic cyc(input logic r0, w0, input logic [15:0] a0, input logic [7:0] d0,
                     input logic r1, w1, input logic [15:0] a1, input logic [7:0] d1);
    logic [20:0] e0, e1;
    logic [7:0] x0, x1, er0, er1;
    logic s0, s1, p0, p1, mw0, mw1;
    x0 = 8'($urandom); x1 = 8'($urandom);
    c0_req = r0; c0_we = w0; c0_addr = a0; c0_wdata = d0; c0_ext_rdata = x0;
    c1_req = r1; c1_we = w1; c1_addr = a1; c1_wdata = d1; c1_ext_rdata = x1;
    e0 = mdec(r0, m_info[0], a0);
    e1 = mdec(r1, m_info[1], a1);
    #1;
    check(c0_tgt == e0[20:18] && c0_taddr == e0[17:0] && c0_wr == (r0 && w0 && e0[20:18] != 0),
          r0 ? ttag(e0[20:18]) : "R11", "cpu0 decode", {c0_wr, c0_tgt, c0_taddr}, e0);
    check(c1_tgt == e1[20:18] && c1_taddr == e1[17:0] && c1_wr == (r1 && w1 && e1[20:18] != 0),
          r1 ? ttag(e1[20:18]) : "R11", "cpu1 decode", {c1_wr, c1_tgt, c1_taddr}, e1);
    s0 = r0 && !w0 && e0[20:18] == 3'd4 && a0[11:4] == 8'hC4;
    s1 = r1 && !w1 && e1[20:18] == 3'd4 && a1[11:4] == 8'hC4;
    p0 = r0 && !w0 && m_info[0][6] && (!a0[15] || a0[15:13] == 3'b110);
    p1 = r1 && !w1 && m_info[1][6] && (!a1[15] || a1[15:13] == 3'b110);
    er0 = (r0 && !w0) ? ((e0[20:18] == 0) ? 8'h00 : s0 ? 8'hFF : x0) : 8'h00;
    er1 = (r1 && !w1) ? ((e1[20:18] == 0) ? 8'h00 : s1 ? 8'hFF : x1) : 8'h00;
    mw0 = r0 && w0 && e0[20:18] == 3'd4 && !a0[11];
    mw1 = r1 && w1 && e1[20:18] == 3'd4 && !a1[11];
    @(posedge clk);
    if (mw0) mapwr(a0, d0);
    else if (mw1) mapwr(a1, d1);
    if (p0 || p1) m_irq = 1'b1;
    else if (s0 || s1) m_irq = 1'b0;
    #1;
    check(c0_rdata == er0, s0 ? "R6" : (r0 && !w0 && e0[20:18] == 0) ? "R3" : "R9",
          "cpu0 rdata", c0_rdata, er0);
    check(c1_rdata == er1, s1 ? "R6" : (r1 && !w1 && e1[20:18] == 0) ? "R3" : "R9",
          "cpu1 rdata", c1_rdata, er1);
    check(perr_irq == m_irq, "R6", "perr_irq", perr_irq, m_irq);
    @(negedge clk);
    c0_req = 0; c1_req = 0; c0_we = 0; c1_we = 0;
  endtask

  task automatic one(input int cpu, input logic w, input logic [15:0] a, input logic [7:0] d);
    if (cpu == 0) cyc(1, w, a, d, 0, 0, 16'h0, 8'h0);
    else cyc(0, 0, 16'h0, 8'h0, 1, w, a, d);
  endtask

  task automatic set_info(input int cpu, input logic [7:0] v);
    if (cpu == 0) begin c0_info_we = 1; c0_info_wdata = v; end
    else begin c1_info_we = 1; c1_info_wdata = v; end
    @(posedge clk);
    m_info[cpu] = v;
    #1;
    check(c0_info == m_info[0], "R10", "cpu0 ctrl", c0_info, m_info[0]);
    check(c1_info == m_info[1], "R10", "cpu1 ctrl", c1_info, m_info[1]);
    @(negedge clk);
    c0_info_we = 0; c1_info_we = 0;
  endtask

  task automatic probe(input int cpu, input logic [15:0] a, output logic [2:0] t, output logic [17:0] ta);
    if (cpu == 0) begin c0_req = 1; c0_we = 0; c0_addr = a; end
    else begin c1_req = 1; c1_we = 0; c1_addr = a; end
    #1;
    t  = (cpu == 0) ? c0_tgt : c1_tgt;
    ta = (cpu == 0) ? c0_taddr : c1_taddr;
    c0_req = 0; c1_req = 0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [2:0] t;
    logic [17:0] ta;
    void'($urandom(32'h5eed_1234));
    m_info[0] = 8'h00; m_info[1] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check(c0_info == 0 && c1_info == 0, "R1", "ctrl in reset", {c0_info, c1_info}, 0);
    check(!perr_irq && c0_rdata == 0 && c1_rdata == 0, "R1", "irq/rdata in reset",
          {perr_irq, c0_rdata, c1_rdata}, 0);
    check(c0_tgt == 0 && c1_tgt == 0, "R1", "target in reset", {c0_tgt, c1_tgt}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(c0_info == 0 && c1_info == 0 && !perr_irq, "R1", "after reset", {c0_info, c1_info, perr_irq}, 0);

    // fill the whole table (R7), mixing matching and non-matching card qualifiers
    for (int i = 0; i < 1024; i++) begin
      int k;
      logic [7:0] lv;
      k = int'($urandom % 4);
      lv = (k < 2) ? 8'h80 : (k == 2) ? (8'h80 | 8'(1 + $urandom % 7)) : (8'($urandom) & 8'h7F);
      one(i % 2, 1, 16'hF000 | 16'(($urandom % 1024) << 1), lv);
      one((i + 1) % 2, 1, 16'hF000 | 16'(i << 1) | 16'h1, 8'($urandom));
    end

    set_info(0, 8'h07);
    set_info(1, 8'h00);

    // R7: present entry via matching latch
    one(1, 1, 16'hF000, 8'h80);
    one(1, 1, 16'hF1C5, 8'hD5);
    set_info(0, 8'h87);
    probe(0, 16'h10AB, t, ta);
    check(t == 3'd1 && ta == {7'h55, 11'h0AB}, "R7", "stored entry", {t, ta}, {3'd1, 7'h55, 11'h0AB});
    // R7: card mismatch leaves page absent
    one(1, 1, 16'hF000, 8'h82);
    one(1, 1, 16'hF1C5, 8'h55);
    probe(0, 16'h10AB, t, ta);
    check(t == 3'd0 && ta == 0, "R7", "card mismatch", {t, ta}, 0);
    one(0, 0, 16'h10AB, 8'h00);
    check(c0_rdata == 8'h00, "R3", "absent read", c0_rdata, 8'h00);

    // R8: same-cycle table writes, processor 0 wins
    set_info(0, 8'h07);
    one(0, 1, 16'hF000, 8'h80);
    cyc(1, 1, 16'hF1C5, 8'h11, 1, 1, 16'hF1C5, 8'h22);
    cyc(1, 1, 16'hF002, 8'h00, 1, 1, 16'hF1C5, 8'h33);
    set_info(0, 8'h87);
    probe(0, 16'h10AB, t, ta);
    check(t == 3'd1 && ta == {7'h11, 11'h0AB}, "R8", "cpu0 priority", {t, ta}, {3'd1, 7'h11, 11'h0AB});

    // window edges
    set_info(0, 8'h07);
    probe(0, 16'h8000, t, ta);
    check(t == 3'd2 && ta == 0, "R4", "video low edge", {t, ta}, {3'd2, 18'h0});
    probe(0, 16'hBFFF, t, ta);
    check(t == 3'd2 && ta == 18'h3FFF, "R4", "video high edge", {t, ta}, {3'd2, 18'h3FFF});
    probe(0, 16'hE03F, t, ta);
    check(t == 3'd3 && ta == 18'h3F, "R5", "card edge", {t, ta}, {3'd3, 18'h3F});
    probe(0, 16'hFFFF, t, ta);
    check(t == 3'd4 && ta == 18'hFFF, "R5", "periph edge", {t, ta}, {3'd4, 18'hFFF});
    foreach (m_map[i]) begin end
    one(0, 0, 16'h7FFF, 0); one(0, 0, 16'h8000, 0); one(0, 0, 16'hBFFF, 0);
    one(0, 0, 16'hC000, 0); one(0, 0, 16'hE03F, 0); one(0, 0, 16'hE040, 0);
    one(0, 0, 16'hEFFF, 0); one(0, 0, 16'hF000, 0); one(0, 1, 16'hE040, 8'h5A);
    set_info(0, 8'hA7);
    one(0, 0, 16'h8000, 0); one(0, 0, 16'hE000, 0); one(0, 0, 16'hFFFF, 0);
    one(0, 1, 16'hBFFF, 8'hC3); one(0, 1, 16'hF800, 8'h3C);

    // R6 parity diagnostic
    set_info(0, 8'h40);
    one(0, 0, 16'h0100, 0);
    check(perr_irq == 1'b1, "R6", "flag set", perr_irq, 1);
    one(1, 0, 16'hFC40, 0);
    check(c1_rdata == 8'hFF && !perr_irq, "R6", "status read", {perr_irq, c1_rdata}, {1'b0, 8'hFF});
    cyc(1, 0, 16'hC010, 8'h00, 1, 0, 16'hFC4F, 8'h00);
    check(perr_irq == 1'b1, "R6", "set beats clear", perr_irq, 1);
    one(1, 0, 16'hFC48, 0);
    check(perr_irq == 1'b0, "R6", "cleared", perr_irq, 0);

    // constrained random traffic on both ports
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ra [2];
      logic rr [2], rw [2];
      if ($urandom % 16 == 0) set_info(int'($urandom % 2), 8'($urandom));
      for (int c = 0; c < 2; c++) begin
        case ($urandom % 8)
          0: ra[c] = 16'($urandom % 16'h8000);
          1: ra[c] = 16'h8000 | 16'($urandom % 16'h4000);
          2: ra[c] = 16'hC000 | 16'($urandom % 16'h2000);
          3: ra[c] = 16'hE000 | 16'($urandom % 16'h80);
          4: ra[c] = 16'hF000 | 16'($urandom % 16'h800);
          5: ra[c] = 16'hFC40 | 16'($urandom % 16);
          6: ra[c] = 16'hF800 | 16'($urandom % 16'h800);
          default: ra[c] = 16'($urandom);
        endcase
        rr[c] = ($urandom % 4) != 0;
        rw[c] = ($urandom % 3) == 0;
      end
      cyc(rr[0], rw[0], ra[0], 8'($urandom), rr[1], rw[1], ra[1], 8'($urandom));
    end
    finish_run();
  end
endmodule